// File: doc/BRIEF.md
# Quasi-Bidirectional Port Pin Driver

This block is the drive-control logic of one 8-bit general-purpose port of a small microcontroller. Software writes an output latch and can read it back. Each pin is driven in one of four states: strong low, weak pull-up, strong pull-up, or float. A pin whose latch bit is 1 sits weakly high, or floats in the open-drain variant. An outside device can then pull it low, so the pin works as an input. The pin level returns through a synchronizer on a separate read path. Read-modify-write sequences use the latch read path.

Each pin has an alternate-function output and input. The alternate output is ANDed with the latch, so a peripheral can drive a pin only while software leaves its latch bit at 1. During an external memory access the port can carry an address or data byte in place of the latch value, and it drives 1s strongly. When the access uses a short 8-bit address, the high-address port keeps presenting its own latch. A parameter selects the open-drain variant, which has no internal pull-up and floats on 1 outside bus cycles. When a write changes a latch bit from 0 to 1, the pull-up variant applies a strong pull-up for one clock to speed up the rising edge.

Top module: `qport`

## Requirements
- R1: After reset every latch bit reads 1, no pin is driven low, and the read-pin path returns all ones. Pull-up variant pins are weakly high; open-drain variant pins float.
- R2: A write updates the latch on the next clock edge, and the read-latch path then returns the written byte. Without a write the latch holds its value.
- R3: Outside a full bus cycle, a pin whose effective output is 0 is driven strong low and has neither pull-up enabled.
- R4: In the pull-up variant, outside a full bus cycle and a boost cycle, a pin whose effective output is 1 has only the weak pull-up enabled.
- R5: The read-pin path shows the pin input as it was two clock edges earlier. An external low on a pin whose latch is 1 therefore reads as 0.
- R6: The effective output of a pin is the AND of its latch bit and its alternate-function output. The alternate-function input equals the synchronized pin level ANDed with the latch bit.
- R7: In the pull-up variant, the clock after a write that changes a latch bit from 0 to 1, that pin's strong pull-up is on for exactly one cycle if its effective output is 1. Rewriting a 1 over a 1 gives no strong pull-up.
- R8: In the open-drain variant the weak pull-up is never enabled. Outside a full bus cycle, a pin with effective output 1 is not driven at all.
- R9: During a full bus cycle (bus select high, short-address flag low), each pin carries the bus byte: 0 bits are driven strong low and 1 bits strong high in both variants. Latch and alternate outputs have no effect, and the latch keeps its value.
- R10: When bus select is high with the short-address flag set, the pins behave exactly as outside a bus cycle and present the latch value.
- R11: For each pin, at most one of strong-low, weak pull-up and strong pull-up is enabled at a time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Latch write strobe |
| wr_data | input | WIDTH | Byte to write into the latch |
| rd_latch | output | WIDTH | Latch contents for read-modify-write |
| rd_pin | output | WIDTH | Synchronized pin levels |
| alt_out | input | WIDTH | Alternate-function outputs, 1 when idle |
| alt_in | output | WIDTH | Alternate-function inputs, gated by latch |
| bus_sel | input | 1 | External bus cycle uses this port |
| bus_addr8 | input | 1 | Bus cycle uses a short 8-bit address |
| bus_data | input | WIDTH | Address or data byte from the bus unit |
| pin_in | input | WIDTH | Pad input levels |
| drv_low | output | WIDTH | Per-pin strong pull-down enable |
| drv_weak | output | WIDTH | Per-pin weak pull-up enable |
| drv_strong | output | WIDTH | Per-pin strong pull-up enable |

## Verification
A wrong latch bit shows on the drive outputs and on the read-latch path in the cycle after the write that set it. A stuck or extra boost flag shows as a strong pull-up that appears or lasts one cycle too long, so every write cycle is compared exactly. A synchronizer that is too short or too long shifts the read-pin and alternate-input values by a cycle against the two-edge model. Bus-select errors show at once as combinational mismatches on all three drive vectors.

// File: rtl/qport_pkg.sv
package qport_pkg;

    typedef enum logic [1:0] {
        DRV_FLOAT  = 2'd0,
        DRV_LOW    = 2'd1,
        DRV_WEAK   = 2'd2,
        DRV_STRONG = 2'd3
    } drive_e;

    // Select one drive state for a pin from its value and context
    function automatic drive_e pick_drive(input logic open_drain,
                                          input logic value,
                                          input logic on_bus,
                                          input logic boost);
        drive_e res;
        if (!value)          res = DRV_LOW;
        else if (on_bus)     res = DRV_STRONG;
        else if (open_drain) res = DRV_FLOAT;
        else if (boost)      res = DRV_STRONG;
        else                 res = DRV_WEAK;
        return res;
    endfunction

endpackage

// File: rtl/qport_sync.sv
module qport_sync #(
    parameter int WIDTH  = 8,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);

    localparam int LAST = STAGES - 1;

    logic [WIDTH-1:0] stg_d [STAGES];
    logic [WIDTH-1:0] stg_q [STAGES];

    always_comb begin
        stg_d[0] = async_in;
        for (int s = 1; s < STAGES; s++) begin
            stg_d[s] = stg_q[s-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int s = 0; s < STAGES; s++) begin
                stg_q[s] <= '1;
            end
        end else begin
            for (int s = 0; s < STAGES; s++) begin
                stg_q[s] <= stg_d[s];
            end
        end
    end

    assign sync_out = stg_q[LAST];

endmodule

// File: rtl/qport_latch.sv
module qport_latch #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [WIDTH-1:0] wr_data,
    output logic [WIDTH-1:0] latch_q,
    output logic [WIDTH-1:0] boost_q
);

    typedef struct packed {
        logic [WIDTH-1:0] latch;
        logic [WIDTH-1:0] boost;
    } state_t;

    state_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.boost = '0;
        if (wr_en) begin
            st_d.latch = wr_data;
            st_d.boost = wr_data & ~st_q.latch;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.latch <= '1;
            st_q.boost <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign latch_q = st_q.latch;
    assign boost_q = st_q.boost;

endmodule

// File: rtl/qport_drive.sv
module qport_drive
    import qport_pkg::*;
#(
    parameter int WIDTH      = 8,
    parameter bit OPEN_DRAIN = 1'b0
) (
    input  logic [WIDTH-1:0] latch_q,
    input  logic [WIDTH-1:0] boost_q,
    input  logic [WIDTH-1:0] alt_out,
    input  logic             bus_sel,
    input  logic             bus_addr8,
    input  logic [WIDTH-1:0] bus_data,
    output logic [WIDTH-1:0] drv_low,
    output logic [WIDTH-1:0] drv_weak,
    output logic [WIDTH-1:0] drv_strong
);

    logic             on_bus;
    logic [WIDTH-1:0] value;

    assign on_bus = bus_sel & ~bus_addr8;
    assign value  = on_bus ? bus_data : (latch_q & alt_out);

    for (genvar i = 0; i < WIDTH; i++) begin : g_pin
        drive_e mode;
        always_comb begin
            mode          = pick_drive(OPEN_DRAIN, value[i], on_bus, boost_q[i]);
            drv_low[i]    = (mode == DRV_LOW);
            drv_weak[i]   = (mode == DRV_WEAK);
            drv_strong[i] = (mode == DRV_STRONG);
        end
    end

endmodule

// File: rtl/qport.sv
module qport #(
    parameter int WIDTH       = 8,
    parameter bit OPEN_DRAIN  = 1'b0,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [WIDTH-1:0] wr_data,
    output logic [WIDTH-1:0] rd_latch,
    output logic [WIDTH-1:0] rd_pin,
    input  logic [WIDTH-1:0] alt_out,
    output logic [WIDTH-1:0] alt_in,
    input  logic             bus_sel,
    input  logic             bus_addr8,
    input  logic [WIDTH-1:0] bus_data,
    input  logic [WIDTH-1:0] pin_in,
    output logic [WIDTH-1:0] drv_low,
    output logic [WIDTH-1:0] drv_weak,
    output logic [WIDTH-1:0] drv_strong
);

    logic [WIDTH-1:0] latch_q;
    logic [WIDTH-1:0] boost_q;
    logic [WIDTH-1:0] pin_sync;

    qport_latch #(.WIDTH(WIDTH)) u_latch (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .latch_q (latch_q),
        .boost_q (boost_q)
    );

    qport_sync #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (pin_in),
        .sync_out (pin_sync)
    );

    qport_drive #(.WIDTH(WIDTH), .OPEN_DRAIN(OPEN_DRAIN)) u_drive (
        .latch_q    (latch_q),
        .boost_q    (boost_q),
        .alt_out    (alt_out),
        .bus_sel    (bus_sel),
        .bus_addr8  (bus_addr8),
        .bus_data   (bus_data),
        .drv_low    (drv_low),
        .drv_weak   (drv_weak),
        .drv_strong (drv_strong)
    );

    assign rd_latch = latch_q;
    assign rd_pin   = pin_sync;
    assign alt_in   = pin_sync & latch_q;

endmodule

// File: rtl/qport_chk.sv
module qport_chk #(
    parameter int WIDTH       = 8,
    parameter bit OPEN_DRAIN  = 1'b0,
    parameter int SYNC_STAGES = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wr_en,
    input logic [WIDTH-1:0] wr_data,
    input logic [WIDTH-1:0] rd_latch,
    input logic [WIDTH-1:0] rd_pin,
    input logic [WIDTH-1:0] alt_out,
    input logic [WIDTH-1:0] alt_in,
    input logic             bus_sel,
    input logic             bus_addr8,
    input logic [WIDTH-1:0] bus_data,
    input logic [WIDTH-1:0] pin_in,
    input logic [WIDTH-1:0] drv_low,
    input logic [WIDTH-1:0] drv_weak,
    input logic [WIDTH-1:0] drv_strong
);

    logic [1:0] cyc_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)           cyc_q <= '0;
        else if (cyc_q != 2'd2) cyc_q <= cyc_q + 2'd1;
    end

    AST_RESET_ONES: assert property (@(posedge clk)
        $rose(rst_n) |-> (rd_latch == '1 && drv_low == '0)); // R1

    AST_WRITE_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> rd_latch == $past(wr_data)); // R2

    AST_HOLD_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(rd_latch)); // R2

    AST_LOW_FROM_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_sel && !bus_addr8) |-> drv_low == ~(rd_latch & alt_out)); // R3

    AST_BUS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && !bus_addr8) |-> drv_low == ~bus_data); // R9

    AST_NO_BOOST_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> ((bus_sel && !bus_addr8) || drv_strong == '0)); // R7

    AST_ALT_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        (alt_in & ~rd_latch) == '0); // R6

    AST_DRIVE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        ((drv_low & drv_weak) | (drv_low & drv_strong) | (drv_weak & drv_strong)) == '0); // R11

    if (SYNC_STAGES == 2) begin : g_sync_chk
        AST_PIN_DELAY: assert property (@(posedge clk) disable iff (!rst_n)
            (cyc_q == 2'd2) |-> rd_pin == $past(pin_in, 2)); // R5
    end

    if (OPEN_DRAIN) begin : g_od_chk
        AST_OD_NO_WEAK: assert property (@(posedge clk) disable iff (!rst_n)
            drv_weak == '0); // R8
    end

endmodule

bind qport qport_chk #(
    .WIDTH(WIDTH),
    .OPEN_DRAIN(OPEN_DRAIN),
    .SYNC_STAGES(SYNC_STAGES)
) u_chk (.*);

// File: tb/qport_tb.sv
module qport_tb;

    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         wr_en = 1'b0;
    logic [W-1:0] wr_data = '0;
    logic [W-1:0] alt_out = '1;
    logic         bus_sel = 1'b0;
    logic         bus_addr8 = 1'b0;
    logic [W-1:0] bus_data = '0;
    logic [W-1:0] pin_in = '1;

    logic [W-1:0] rl_p, rp_p, ai_p, lo_p, wk_p, st_p;
    logic [W-1:0] rl_o, rp_o, ai_o, lo_o, wk_o, st_o;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    logic [W-1:0] m_latch = '1;
    logic [W-1:0] m_boost = '0;
    logic [W-1:0] m_s1 = '1;
    logic [W-1:0] m_s2 = '1;

    always #2 clk = ~clk;

    qport #(.WIDTH(W), .OPEN_DRAIN(1'b0)) u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .rd_latch(rl_p), .rd_pin(rp_p), .alt_out(alt_out), .alt_in(ai_p),
        .bus_sel(bus_sel), .bus_addr8(bus_addr8), .bus_data(bus_data),
        .pin_in(pin_in), .drv_low(lo_p), .drv_weak(wk_p), .drv_strong(st_p)
    );

    qport #(.WIDTH(W), .OPEN_DRAIN(1'b1)) u_dut_od (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .rd_latch(rl_o), .rd_pin(rp_o), .alt_out(alt_out), .alt_in(ai_o),
        .bus_sel(bus_sel), .bus_addr8(bus_addr8), .bus_data(bus_data),
        .pin_in(pin_in), .drv_low(lo_o), .drv_weak(wk_o), .drv_strong(st_o)
    );

    // Expected {low, weak, strong} from the requirements
    function automatic logic [3*W-1:0] exp_drv(input bit od);
        logic         on_bus;
        logic [W-1:0] v, lo, wk, st;
        on_bus = bus_sel & ~bus_addr8;
        v  = on_bus ? bus_data : (m_latch & alt_out);
        lo = ~v;
        if (on_bus)  st = v;
        else if (od) st = '0;
        else         st = v & m_boost;
        wk = od ? '0 : (v & ~st & {W{~on_bus}});
        return {lo, wk, st};
    endfunction

    task automatic chk(input string req, input string what,
                       input logic [W-1:0] act, input logic [W-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %02h expected %02h", req, what, act, exp);
        end
    endtask

    task automatic check_all(input string req);
        logic [3*W-1:0] ep, eo;
        ep = exp_drv(1'b0);
        eo = exp_drv(1'b1);
        chk(req, "pu low",    lo_p, ep[3*W-1:2*W]);
        chk(req, "pu weak",   wk_p, ep[2*W-1:W]);
        chk(req, "pu strong", st_p, ep[W-1:0]);
        chk(req, "od low",    lo_o, eo[3*W-1:2*W]);
        chk(req, "od weak",   wk_o, eo[2*W-1:W]);
        chk(req, "od strong", st_o, eo[W-1:0]);
        chk(req, "rd_latch",  rl_p, m_latch);
        chk(req, "rd_latch od", rl_o, m_latch);
        chk(req, "rd_pin",    rp_p, m_s2);
        chk(req, "rd_pin od", rp_o, m_s2);
        chk(req, "alt_in",    ai_p, m_s2 & m_latch);
    endtask

    task automatic step(input string req, input logic we, input logic [W-1:0] wd,
                        input logic [W-1:0] pin, input logic [W-1:0] alt,
                        input logic bs, input logic a8, input logic [W-1:0] bd);
        wr_en = we; wr_data = wd; pin_in = pin; alt_out = alt;
        bus_sel = bs; bus_addr8 = a8; bus_data = bd;
        @(posedge clk);
        if (we) begin
            m_boost = wd & ~m_latch;
            m_latch = wd;
        end else begin
            m_boost = '0;
        end
        m_s2 = m_s1;
        m_s1 = pin;
        @(negedge clk);
        check_all(req);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  %0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        check_all("R1 reset");
        // R2 R3: all zeros written, every pin strong low
        step("R2 R3 write zeros", 1'b1, 8'h00, 8'hFF, 8'hFF, 1'b0, 1'b0, 8'h00);
        // R7: zero to one gives one boost cycle
        step("R7 boost", 1'b1, 8'hFF, 8'hFF, 8'hFF, 1'b0, 1'b0, 8'h00);
        step("R4 R7 boost ends", 1'b0, 8'h00, 8'hFF, 8'hFF, 1'b0, 1'b0, 8'h00);
        step("R7 rewrite ones", 1'b1, 8'hFF, 8'hFF, 8'hFF, 1'b0, 1'b0, 8'h00);
        // R5: external low read after two edges
        step("R5 pin low 1", 1'b0, 8'h00, 8'h0F, 8'hFF, 1'b0, 1'b0, 8'h00);
        step("R5 pin low 2", 1'b0, 8'h00, 8'h0F, 8'hFF, 1'b0, 1'b0, 8'h00);
        step("R5 R8 hold", 1'b0, 8'h00, 8'h0F, 8'hFF, 1'b0, 1'b0, 8'h00);
        // R6: alternate function gated by latch
        step("R6 alt latch", 1'b1, 8'hF0, 8'hFF, 8'h3C, 1'b0, 1'b0, 8'h00);
        step("R6 alt in", 1'b0, 8'h00, 8'hFF, 8'h3C, 1'b0, 1'b0, 8'h00);
        // R9: bus overrides latch; R10: short address keeps latch
        step("R9 bus", 1'b0, 8'h00, 8'hFF, 8'h00, 1'b1, 1'b0, 8'h96);
        step("R9 bus write", 1'b1, 8'h5A, 8'hFF, 8'hFF, 1'b1, 1'b0, 8'h69);
        step("R10 short addr", 1'b0, 8'h00, 8'hFF, 8'hFF, 1'b1, 1'b1, 8'h33);
        for (int k = 0; k < 400; k++) begin
            logic         we, bs, a8;
            logic [W-1:0] wd, pin, alt, bd;
            we  = ($urandom % 4) == 0;
            bs  = ($urandom % 4) == 0;
            a8  = ($urandom % 2) == 0;
            wd  = W'($urandom);
            pin = W'($urandom);
            alt = (($urandom % 2) == 0) ? '1 : W'($urandom);
            bd  = W'($urandom);
            step("random R2 R3 R4 R5 R6 R7 R8 R9 R10 R11", we, wd, pin, alt, bs, a8, bd);
        end
        finish_run();
    end

    initial begin
        void'($urandom(32'h5EED_0042));
    end

endmodule